// File: doc/BRIEF.md
# Programmable Square-Wave Beep Generator

This block makes a square-wave warning tone from the 48 kHz frame-sync strobe of an audio link. An 8-bit divider sets the pitch. The output changes level once every 2 × divider strobes, so the tone frequency is 48 kHz / (4 × divider). That gives about 12 kHz at divider 1 and about 47 Hz at divider 255. A divider of zero switches the tone off.

Each audio port has an output-enable bit. While the tone runs, every enabled port sends the tone sample in place of its own audio: the tone replaces the audio, it is not mixed with it. Each tone sample is plus or minus a programmable amplitude code, chosen by the square-wave phase. Ports that are not enabled, and all ports while the tone is off, pass their own audio through unchanged. A status bit reports whether the bus clock may be stopped. It is held low while the device is in the D3 power state and the tone is running, because the tone needs the clock.

Top module: `beep_tone_gen`

## Requirements
- R1: During and right after reset, `beep_active` is 0, `clk_stop_ok` is 1, and every port passes its own audio sample.
- R2: With a non-zero divider D, the square-wave phase toggles after exactly 2×D sync strobes. Clock cycles without a strobe do not advance it.
- R3: A divider of 0 makes `beep_active` 0 and resets the phase and the count on the next clock edge, whatever the current count.
- R4: When the divider changes from one non-zero value to another, the new value first shapes the half-period that starts at the next phase toggle. The half-period in progress keeps the old length.
- R5: The tone sample is the amplitude code when the phase is high. It is the two's-complement negation of the amplitude code when the phase is low.
- R6: While the tone is active, a port whose enable bit is 0 passes its own audio sample unchanged.
- R7: While the tone is active, a port whose enable bit is 1 outputs the tone sample and none of its audio.
- R8: While the tone is inactive, every port outputs its own audio sample.
- R9: `clk_stop_ok` is 0 exactly when `in_d3` is 1 and `beep_active` is 1. Otherwise it is 1.
- R10: When the divider goes from 0 to a non-zero value, the tone starts on the next clock edge with the phase low and a fresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_strobe | input | 1 | One-cycle pulse for each 48 kHz frame |
| divider | input | DIV_W | Pitch divider; 0 switches the tone off |
| amplitude | input | SAMPLE_W | Tone magnitude code |
| port_out_en | input | NUM_PORTS | Per-port output-enable mask |
| audio_in | input | NUM_PORTS×SAMPLE_W | Per-port audio samples, port 0 in the low bits |
| in_d3 | input | 1 | Device is in the D3 power state |
| port_sample | output | NUM_PORTS×SAMPLE_W | Per-port output samples |
| beep_active | output | 1 | Tone is running |
| clk_stop_ok | output | 1 | Bus clock may be stopped |

## Verification
The bench builds the block with three ports and 12-bit samples. The mask then has a mix of enabled and disabled ports, and the wrap of the negated amplitude code is easy to follow. It keeps the full 8-bit divider, so the longest half-period of 510 strobes at divider 255 is run in full, along with the shortest at divider 1. Strobe gaps of one to three cycles separate strobe counting from clock counting.

// File: rtl/beep_pkg.sv
// Package: types shared by the beep tone blocks.
// Assumes: nothing beyond IEEE 1800-2017.
package beep_pkg;
    // Square-wave half the tone is currently in.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;
endpackage

// File: rtl/beep_divider.sv
// Module: beep_divider
// Purpose: counts sync strobes and toggles the square-wave phase every
// 2*divider strobes. A new divider value is taken at half-period
// boundaries. A zero divider stops the tone on the next edge.
// Assumes: sync_strobe is a single-cycle pulse; divider is held stable by
// the register that drives it.
module beep_divider
    import beep_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_strobe,
    input  logic [DIV_W-1:0] divider,
    output logic             tone_on,
    output phase_t           tone_phase
);
    localparam int CNT_W = DIV_W + 1;

    logic [DIV_W-1:0] cur_div;
    logic [CNT_W-1:0] cnt;
    phase_t           phase_q;
    logic [CNT_W-1:0] half_last;
    logic             at_edge;

    // Last count index of the current half-period (2*cur_div - 1).
    assign half_last = {cur_div, 1'b0} - CNT_W'(1);
    assign at_edge   = sync_strobe && (cnt == half_last);

    // Divider latch, strobe counter and phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_div <= '0;
            cnt     <= '0;
            phase_q <= PH_LOW;
        end else if (divider == '0) begin
            cur_div <= '0;
            cnt     <= '0;
            phase_q <= PH_LOW;
        end else if (cur_div == '0) begin
            cur_div <= divider;
            cnt     <= '0;
            phase_q <= PH_LOW;
        end else if (at_edge) begin
            cnt     <= '0;
            phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
            cur_div <= divider;
        end else if (sync_strobe) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    assign tone_on    = (cur_div != '0);
    assign tone_phase = phase_q;

    // A zero divider turns the tone off on the following edge.
    assert_zero_div_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (divider == '0) |=> (!tone_on && tone_phase == PH_LOW && cnt == '0));

    // The count never passes the end of the half-period.
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tone_on |-> (cnt <= half_last));

    // Without a strobe the phase holds.
    assert_phase_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_on && !sync_strobe && divider != '0) |=> $stable(tone_phase));

    // The latched divider changes only at a boundary.
    assert_div_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_on && divider != '0 && !at_edge) |=> $stable(cur_div));

    // Starting from idle gives a fresh, low phase.
    assert_fresh_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tone_on && divider != '0) |=> (tone_on && tone_phase == PH_LOW && cnt == '0));
endmodule

// File: rtl/beep_tone_shaper.sv
// Module: beep_tone_shaper
// Purpose: maps the square-wave phase to a signed sample code:
// +amplitude when the phase is high, its two's-complement negation when low.
// Assumes: amplitude is a magnitude that fits in SAMPLE_W-1 bits.
module beep_tone_shaper
    import beep_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  phase_t              tone_phase,
    input  logic [SAMPLE_W-1:0] amplitude,
    output logic [SAMPLE_W-1:0] tone_code
);
    // Sign selection from phase.
    always_comb begin
        if (tone_phase == PH_HIGH) tone_code = amplitude;
        else                       tone_code = (~amplitude) + SAMPLE_W'(1);
    end
endmodule

// File: rtl/beep_port_mux.sv
// Module: beep_port_mux
// Purpose: one port's output select. The tone replaces the audio while the
// tone is on and the port is enabled as an output; otherwise the port's
// audio passes through.
// Assumes: tone_code is already signed and in range.
module beep_port_mux #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tone_on,
    input  logic                out_en,
    input  logic [SAMPLE_W-1:0] tone_code,
    input  logic [SAMPLE_W-1:0] audio,
    output logic [SAMPLE_W-1:0] sample_out
);
    // Select tone or pass-through.
    always_comb begin
        if (tone_on && out_en) sample_out = tone_code;
        else                   sample_out = audio;
    end

    // Disabled ports pass their audio.
    assert_disabled_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (sample_out == audio));
endmodule

// File: rtl/beep_tone_gen.sv
// Module: beep_tone_gen (top)
// Purpose: digital beep generator. It divides the frame strobe into a square
// wave, shapes it into sample codes, puts them on the output-enabled ports
// and keeps the bus clock running in D3 while the tone is on.
// Assumes: the port samples are packed with port 0 in the low bits.
module beep_tone_gen
    import beep_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int SAMPLE_W  = 16,
    parameter int DIV_W     = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sync_strobe,
    input  logic [DIV_W-1:0]              divider,
    input  logic [SAMPLE_W-1:0]           amplitude,
    input  logic [NUM_PORTS-1:0]          port_out_en,
    input  logic [NUM_PORTS*SAMPLE_W-1:0] audio_in,
    input  logic                          in_d3,
    output logic [NUM_PORTS*SAMPLE_W-1:0] port_sample,
    output logic                          beep_active,
    output logic                          clk_stop_ok
);
    logic                tone_on;
    phase_t              tone_phase;
    logic [SAMPLE_W-1:0] tone_code;

    beep_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .sync_strobe(sync_strobe),
        .divider(divider), .tone_on(tone_on), .tone_phase(tone_phase)
    );

    beep_tone_shaper #(.SAMPLE_W(SAMPLE_W)) u_shape (
        .tone_phase(tone_phase), .amplitude(amplitude), .tone_code(tone_code)
    );

    // One output select per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        beep_port_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
            .clk(clk), .rst_n(rst_n), .tone_on(tone_on),
            .out_en(port_out_en[p]), .tone_code(tone_code),
            .audio(audio_in[p*SAMPLE_W +: SAMPLE_W]),
            .sample_out(port_sample[p*SAMPLE_W +: SAMPLE_W])
        );

        // An enabled port carries the +/- amplitude code while the tone is on.
        assert_tone_on_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (tone_on && port_out_en[p]) |->
            (port_sample[p*SAMPLE_W +: SAMPLE_W] == amplitude ||
             port_sample[p*SAMPLE_W +: SAMPLE_W] == (~amplitude) + SAMPLE_W'(1)));
    end

    assign beep_active = tone_on;
    // Clock stop is refused while the tone needs the clock in D3.
    assign clk_stop_ok = !(in_d3 && tone_on);

    // When idle, all ports pass their own audio.
    assert_idle_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !beep_active |-> (port_sample == audio_in));
endmodule

// File: tb/test_beep_tone_gen.sv
module test_beep_tone_gen;
    localparam int NP = 3;
    localparam int SW = 12;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_strobe = 1'b0;
    logic [DW-1:0] divider = '0;
    logic [SW-1:0] amplitude = 12'h3A5;
    logic [NP-1:0] port_out_en = 3'b101;
    logic [NP*SW-1:0] audio_in = '0;
    logic in_d3 = 1'b0;
    logic [NP*SW-1:0] port_sample;
    logic beep_active, clk_stop_ok;

    always #10 clk = ~clk;  // 50 MHz

    beep_tone_gen #(.NUM_PORTS(NP), .SAMPLE_W(SW), .DIV_W(DW)) i_beep_tone_gen (
        .clk(clk), .rst_n(rst_n), .sync_strobe(sync_strobe), .divider(divider),
        .amplitude(amplitude), .port_out_en(port_out_en), .audio_in(audio_in),
        .in_d3(in_d3), .port_sample(port_sample), .beep_active(beep_active),
        .clk_stop_ok(clk_stop_ok)
    );

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    int strobe_gap = 1;
    bit done = 0;

    // Behavioural reference: the tone as a strobe count within a half-period.
    int m_div = 0;
    int m_cnt = 0;
    int m_phase = 0;
    always @(posedge clk) begin
        if (!rst_n || divider == 0) begin
            m_div <= 0; m_cnt <= 0; m_phase <= 0;
        end else if (m_div == 0) begin
            m_div <= int'(divider); m_cnt <= 0; m_phase <= 0;
        end else if (sync_strobe) begin
            if (m_cnt + 1 == 2 * m_div) begin
                m_cnt <= 0; m_phase <= 1 - m_phase; m_div <= int'(divider);
            end else m_cnt <= m_cnt + 1;
        end
    end

    function automatic logic [SW-1:0] exp_port(int p);
        logic [SW-1:0] neg;
        neg = SW'(-int'(amplitude));
        if (m_div != 0 && port_out_en[p]) return (m_phase == 1) ? amplitude : neg;
        return audio_in[p*SW +: SW];
    endfunction

    task automatic check(string req, string what, logic [SW-1:0] act, logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < NP; p++)
            check(cur_req, $sformatf("port%0d", p), port_sample[p*SW +: SW], exp_port(p));
        check(cur_req, "beep_active", SW'(beep_active), SW'(m_div != 0));
        check("R9", "clk_stop_ok", SW'(clk_stop_ok), SW'(!(in_d3 && m_div != 0)));
    endtask

    task automatic drive();
        audio_in = {$urandom, $urandom};
        sync_strobe = (strobe_gap <= 1) ? 1'b1 : (($urandom % strobe_gap) == 0);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            drive();
        end
    endtask

    initial begin
        drive();
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1", "beep_active in reset", SW'(beep_active), '0);
        check("R1", "clk_stop_ok in reset", SW'(clk_stop_ok), SW'(1));
        check("R1", "port0 passthrough", port_sample[SW-1:0], audio_in[SW-1:0]);
        rst_n = 1'b1;
        step(3);

        // R10: start from idle, phase low on the next edge.
        cur_req = "R10";
        divider = 8'd3;
        step(1);
        check("R10", "started low", port_sample[SW-1:0], SW'(-int'(amplitude)));

        // R2: half-period of 2*D strobes with a strobe every cycle.
        cur_req = "R2";
        strobe_gap = 1;
        begin
            int n = 0;
            while (port_sample[SW-1:0] != amplitude) step(1);
            while (port_sample[SW-1:0] == amplitude) begin step(1); n++; end
            checks++;
            if (n != 6) begin errors++; $display("FAIL R2 half-period: actual=%0d expected=6", n); end
        end

        // R6/R7/R5 with several masks and amplitudes.
        cur_req = "R7"; port_out_en = 3'b111; step(30);
        cur_req = "R6"; port_out_en = 3'b010; step(30);
        cur_req = "R5"; amplitude = 12'h001; port_out_en = 3'b111; step(30);
        amplitude = 12'h7FF; step(30);

        // R4: divider changes mid-period.
        cur_req = "R4"; strobe_gap = 2;
        step(5); divider = 8'd5; step(40); divider = 8'd2; step(3); divider = 8'd4; step(60);

        // R9: D3 with and without the tone.
        cur_req = "R9"; in_d3 = 1'b1; step(10);

        // R3: zero divider stops at once.
        cur_req = "R3"; divider = 8'd0;
        step(1);
        check("R3", "beep off after zero", SW'(beep_active), '0);
        check("R9", "clk_stop_ok idle in D3", SW'(clk_stop_ok), SW'(1));
        cur_req = "R8"; step(20);
        in_d3 = 1'b0;

        // Shortest and longest divider, sparse strobes.
        cur_req = "R2"; divider = 8'd1; strobe_gap = 3; step(200);
        divider = 8'd0; step(2);
        divider = 8'd255; strobe_gap = 1; in_d3 = 1'b1; step(1600);
        cur_req = "R3"; divider = 8'd0; step(5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule